// File: doc/BRIEF.md
# Stalling Host Read Port for a Learned-Entry Queue

This block is the processor-facing read port of a lookup table engine whose core is shared with a synchronous search/learn port. The synchronous side always owns the core when it needs it, and it signals this on `core_busy`. Each newly learned table entry is placed in a small learned-entry queue as a 96-bit record. The processor reads each record back as three 32-bit words.

A processor cycle starts when `proc_cs` is raised with an address. It ends in the cycle in which the block drives `proc_ready` high, and `proc_rdata` is valid in that cycle. A first-word read takes the oldest record out of the queue. Removing that record counts as a core access, so while the core is busy the block holds `proc_ready` low and the cycle is stretched. The removed record is copied into a holding register. The second and third words come from that register, so those cycles never wait for the core. A read of an empty queue returns zero with an empty flag and does not wait.

Top module: `host_access_port`

## Requirements
- R1: After a synchronous active-high reset, `proc_ready`, `proc_empty` and `proc_rdata` are all zero, the learned queue is empty and the word pointer is 0.
- R2: A record-taking read is either address 1, or address 0 while the word pointer is 0. When the core is free and the queue holds a record, the block raises `proc_ready` one cycle after it samples `proc_cs`. It returns bits [31:0] of the oldest record, removes that record, copies all 96 bits into the holding register and sets the pointer to 1.
- R3: While `core_busy` is high, a record-taking read on a non-empty queue keeps `proc_ready` low. The record is removed at the first clock edge that samples `core_busy` low, and `proc_ready` rises in the cycle after that edge.
- R4: An address 0 read with pointer 1 returns holding-register bits [63:32], and with pointer 2 returns bits [95:64]. Neither read removes a record. Both raise `proc_ready` one cycle after sampling, whatever `core_busy` is.
- R5: After the word at pointer 2 is read, the pointer returns to 0, so the next address 0 read takes a new record.
- R6: An address 1 read always takes a new record and restarts the pointer at 1, even when the current record has only been partly read.
- R7: A record-taking read on an empty queue returns zero with `proc_empty` high. It completes one cycle after sampling even while `core_busy` is high. It clears the holding register and sets the pointer to 1.
- R8: The queue returns records oldest first and holds up to LQ_DEPTH of them. A push while the queue is full is discarded.
- R9: Addresses 2 and 3 return zero one cycle after sampling. They remove no record and leave the pointer unchanged.
- R10: `proc_ready` is high for exactly one cycle per processor cycle. While `proc_cs` stays high after that, no further cycle is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_busy | input | 1 | Synchronous port holds the table core |
| lq_push | input | 1 | Add a learned record to the queue |
| lq_entry | input | 96 | Learned record to add |
| proc_cs | input | 1 | Processor cycle request, held until ready |
| proc_addr | input | 2 | 0 sequential word, 1 first word, 2–3 unused |
| proc_ready | output | 1 | Cycle completes; read data valid |
| proc_rdata | output | 32 | Read data |
| proc_empty | output | 1 | With ready: the queue was empty on a first-word read |

## Verification
The bench sweeps the length of the busy window from zero to three cycles on record-taking reads and on word reads. It counts the exact wait in each case, so a design that stalls word reads, or that removes a record while the core is busy, gives the wrong cycle count. It overfills the queue and then reads it dry, which exposes a design that overwrites the oldest record or keeps the extra push. It also restarts in the middle of a record, reads the unused addresses between word reads, and holds the chip select high past ready. A pointer that drifts or a cycle that is started twice then shows up as a wrong word or a missing record.

// File: rtl/hap_pkg.sv
package hap_pkg;
  localparam int ADDR_SEQ   = 0;
  localparam int ADDR_FIRST = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP, ST_GAP} hap_state_t;
  typedef enum logic [1:0] {SEL_ZERO, SEL_HEAD, SEL_HOLD} hap_sel_t;
endpackage

// File: rtl/hap_lqueue.sv
module hap_lqueue #(
  parameter int ENTRY_W = 96,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic               take_in, take_out;

  assign take_out = pop && (count != '0);
  assign take_in  = push && ((count != CNT_W'(DEPTH)) || take_out);
  assign empty    = (count == '0);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take_in) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (take_in)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (take_out) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({take_in, take_out})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hap_ctrl.sv
module hap_ctrl
  import hap_pkg::*;
#(
  parameter int WORDS  = 3,
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       core_busy,
  input  logic                       q_empty,
  input  logic                       cs,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       ready,
  output logic                       empty_flag,
  output logic                       pop,
  output logic                       hold_load,
  output logic                       hold_clear,
  output logic                       fire,
  output hap_sel_t                   sel,
  output logic [$clog2(WORDS)-1:0]   word_idx
);
  localparam int PTR_W = $clog2(WORDS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WORDS - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  hap_state_t       state, state_nx;
  logic [PTR_W-1:0] ptr, ptr_nx;
  logic             is_seq, is_first, need_pop, empty_ev;

  assign is_seq   = (addr == ADDR_W'(ADDR_SEQ));
  assign is_first = (addr == ADDR_W'(ADDR_FIRST));
  assign need_pop = is_first || (is_seq && (ptr == '0));

  always_comb begin
    state_nx   = state;
    ptr_nx     = ptr;
    pop        = 1'b0;
    hold_load  = 1'b0;
    hold_clear = 1'b0;
    fire       = 1'b0;
    empty_ev   = 1'b0;
    sel        = SEL_ZERO;
    word_idx   = ptr;
    case (state)
      ST_IDLE: begin
        if (cs) begin
          if (need_pop) begin
            if (q_empty) begin
              fire       = 1'b1;
              hold_clear = 1'b1;
              empty_ev   = 1'b1;
              ptr_nx     = PTR_ONE;
              state_nx   = ST_RESP;
            end else if (!core_busy) begin
              pop       = 1'b1;
              hold_load = 1'b1;
              fire      = 1'b1;
              sel       = SEL_HEAD;
              ptr_nx    = PTR_ONE;
              state_nx  = ST_RESP;
            end else begin
              state_nx = ST_WAIT;
            end
          end else if (is_seq) begin
            fire     = 1'b1;
            sel      = SEL_HOLD;
            ptr_nx   = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
            state_nx = ST_RESP;
          end else begin
            fire     = 1'b1;
            state_nx = ST_RESP;
          end
        end
      end
      ST_WAIT: begin
        if (!core_busy) begin
          pop       = 1'b1;
          hold_load = 1'b1;
          fire      = 1'b1;
          sel       = SEL_HEAD;
          ptr_nx    = PTR_ONE;
          state_nx  = ST_RESP;
        end
      end
      ST_RESP: state_nx = cs ? ST_GAP : ST_IDLE;
      ST_GAP:  if (!cs) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      ready      <= 1'b0;
      empty_flag <= 1'b0;
    end else begin
      state      <= state_nx;
      ptr        <= ptr_nx;
      ready      <= fire;
      empty_flag <= empty_ev;
    end
  end
endmodule

// File: rtl/hap_hold.sv
module hap_hold
  import hap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WORD_W*WORDS-1:0]   head,
  input  logic                      load,
  input  logic                      clear,
  input  logic                      fire,
  input  hap_sel_t                  sel,
  input  logic [$clog2(WORDS)-1:0]  word_idx,
  output logic [WORD_W-1:0]         rdata
);
  localparam int ENTRY_W = WORD_W * WORDS;

  logic [ENTRY_W-1:0] hold;
  logic [WORD_W-1:0]  word_mux;

  always_comb begin
    case (sel)
      SEL_HEAD: word_mux = head[WORD_W-1:0];
      SEL_HOLD: word_mux = hold[int'(word_idx)*WORD_W +: WORD_W];
      default:  word_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      rdata <= '0;
    end else begin
      if (load)       hold <= head;
      else if (clear) hold <= '0;
      if (fire) rdata <= word_mux;
    end
  end
endmodule

// File: rtl/host_access_port.sv
module host_access_port
  import hap_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 3,
  parameter int LQ_DEPTH = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     core_busy,
  input  logic                     lq_push,
  input  logic [WORD_W*WORDS-1:0]  lq_entry,
  input  logic                     proc_cs,
  input  logic [ADDR_W-1:0]        proc_addr,
  output logic                     proc_ready,
  output logic [WORD_W-1:0]        proc_rdata,
  output logic                     proc_empty
);
  localparam int ENTRY_W = WORD_W * WORDS;
  localparam int PTR_W   = $clog2(WORDS);

  logic [ENTRY_W-1:0] lq_head;
  logic               lq_empty, lq_pop;
  logic               hold_load, hold_clear, rd_fire;
  hap_sel_t           rd_sel;
  logic [PTR_W-1:0]   rd_idx;

  hap_lqueue #(.ENTRY_W(ENTRY_W), .DEPTH(LQ_DEPTH)) u_lqueue (
    .clk(clk), .rst(rst), .push(lq_push), .din(lq_entry),
    .pop(lq_pop), .head(lq_head), .empty(lq_empty)
  );

  hap_ctrl #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .core_busy(core_busy), .q_empty(lq_empty),
    .cs(proc_cs), .addr(proc_addr), .ready(proc_ready),
    .empty_flag(proc_empty), .pop(lq_pop), .hold_load(hold_load),
    .hold_clear(hold_clear), .fire(rd_fire), .sel(rd_sel), .word_idx(rd_idx)
  );

  hap_hold #(.WORD_W(WORD_W), .WORDS(WORDS)) u_hold (
    .clk(clk), .rst(rst), .head(lq_head), .load(hold_load),
    .clear(hold_clear), .fire(rd_fire), .sel(rd_sel),
    .word_idx(rd_idx), .rdata(proc_rdata)
  );
endmodule

// File: rtl/hap_checker.sv
module hap_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              core_busy,
  input logic              proc_cs,
  input logic              proc_ready,
  input logic [WORD_W-1:0] proc_rdata,
  input logic              proc_empty,
  input logic              pop,
  input logic              q_empty
);
  AST_POP_CORE_FREE: assert property (@(posedge clk) disable iff (rst)
    pop |-> !core_busy);                                         // R3
  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !q_empty);                                           // R8
  AST_POP_THEN_READY: assert property (@(posedge clk) disable iff (rst)
    pop |=> proc_ready);                                         // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    proc_ready |=> !proc_ready);                                 // R10
  AST_READY_HAS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    proc_ready |-> $past(proc_cs));                              // R10
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    proc_empty |-> (proc_ready && proc_rdata == '0));            // R7
endmodule

bind host_access_port hap_checker #(.WORD_W(WORD_W)) u_hap_checker (
  .clk(clk), .rst(rst), .core_busy(core_busy), .proc_cs(proc_cs),
  .proc_ready(proc_ready), .proc_rdata(proc_rdata), .proc_empty(proc_empty),
  .pop(lq_pop), .q_empty(lq_empty)
);

// File: tb/test_host_access_port.sv
module test_host_access_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_busy = 1'b0;
  logic        lq_push = 1'b0;
  logic [95:0] lq_entry = '0;
  logic        proc_cs = 1'b0;
  logic [1:0]  proc_addr = '0;
  logic        proc_ready;
  logic [31:0] proc_rdata;
  logic        proc_empty;

  int checks = 0;
  int errors = 0;

  logic [95:0] mq [8];
  int          m_head = 0, m_cnt = 0, m_ptr = 0;
  logic [95:0] m_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_access_port #(.WORD_W(32), .WORDS(3), .LQ_DEPTH(DEPTH), .ADDR_W(2)) i_host_access_port (
    .clk(clk), .rst(rst), .core_busy(core_busy), .lq_push(lq_push),
    .lq_entry(lq_entry), .proc_cs(proc_cs), .proc_addr(proc_addr),
    .proc_ready(proc_ready), .proc_rdata(proc_rdata), .proc_empty(proc_empty)
  );

  function automatic logic [95:0] rec(input int n);
    logic [31:0] b;
    b = 32'hA000_0000 + 32'(n * 16);
    return {b + 32'd2, b + 32'd1, b};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input int n);
    lq_push  = 1'b1;
    lq_entry = rec(n);
    @(negedge clk);
    lq_push = 1'b0;
    if (m_cnt < DEPTH) begin
      mq[(m_head + m_cnt) % 8] = rec(n);
      m_cnt++;
    end
  endtask

  // a: address, b: busy cycles, hx: extra cycles cs held after ready
  task automatic rd(input logic [1:0] a, input int b, input int hx,
                    input string dtag, input string wtag);
    logic [31:0] e_data;
    logic        e_empty;
    int          e_wait, waited;
    bit          need;
    need = (a == 2'd1) || (a == 2'd0 && m_ptr == 0);
    e_empty = 1'b0;
    e_wait  = 1;
    if (need) begin
      if (m_cnt == 0) begin
        e_data = '0; e_empty = 1'b1; m_hold = '0;
      end else begin
        m_hold = mq[m_head];
        e_data = m_hold[31:0];
        m_head = (m_head + 1) % 8;
        m_cnt--;
        e_wait = b + 1;
      end
      m_ptr = 1;
    end else if (a == 2'd0) begin
      e_data = m_hold[m_ptr*32 +: 32];
      m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
    end else begin
      e_data = '0;
    end
    proc_cs   = 1'b1;
    proc_addr = a;
    core_busy = (b > 0);
    waited = 0;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      waited = k;
      if (proc_ready) break;
      core_busy = (k < b);
    end
    chk(wtag, "wait cycles", 32'(waited), 32'(e_wait));
    chk(dtag, "read data", proc_rdata, e_data);
    chk(dtag, "empty flag", 32'(proc_empty), 32'(e_empty));
    core_busy = 1'b0;
    for (int k = 0; k < hx; k++) begin
      @(negedge clk);
      chk("R10", "ready while cs held", 32'(proc_ready), 32'd0);
    end
    proc_cs = 1'b0;
    @(negedge clk);
    chk("R10", "ready after cycle", 32'(proc_ready), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "ready at reset", 32'(proc_ready), 32'd0);
    chk("R1", "rdata at reset", proc_rdata, 32'd0);
    chk("R1", "empty at reset", 32'(proc_empty), 32'd0);
    // empty queue: no stall even while busy, then zero words
    rd(2'd0, 2, 0, "R7", "R7");
    rd(2'd0, 2, 0, "R7", "R4");
    rd(2'd0, 0, 0, "R7", "R4");
    // overfill: fifth push discarded
    for (int n = 0; n < 5; n++) push(n);
    for (int b = 0; b < 4; b++) begin
      rd(2'd0, b, 0, "R2", "R3");
      rd(2'd0, b, 0, "R4", "R4");
      rd(2'd0, b, 0, "R4", "R5");
    end
    rd(2'd0, 1, 0, "R8", "R8");
    rd(2'd0, 0, 0, "R8", "R4");
    rd(2'd0, 0, 0, "R8", "R4");
    // restart mid-record, unused addresses
    push(10);
    push(11);
    rd(2'd1, 1, 0, "R6", "R3");
    rd(2'd0, 0, 0, "R4", "R4");
    rd(2'd1, 0, 0, "R6", "R2");
    rd(2'd2, 1, 0, "R9", "R9");
    rd(2'd3, 0, 0, "R9", "R9");
    rd(2'd0, 0, 0, "R4", "R4");
    rd(2'd0, 0, 2, "R5", "R10");
    push(12);
    rd(2'd0, 3, 3, "R5", "R3");
    rd(2'd1, 2, 0, "R7", "R7");
    rd(2'd0, 0, 0, "R7", "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule